// File: doc/BRIEF.md
# Dot-Matrix Glyph Scroller

This block moves 8x8 character glyphs across an 8x8 LED dot matrix. It steps through eight stored glyphs in turn. For each glyph it first reads the eight rows from an external synchronous ROM. It then slides the glyph onto the matrix and back off again, one position on each shift tick, in a direction chosen by a 2-bit select. A scan enable walks a one-hot row select over the matrix and presents the column pattern of the selected row.

The sequencing is a three-state machine:
- `ST_FETCH` issues the eight row reads and clears the display.
- `ST_SETTLE` waits one cycle for the last read to return.
- `ST_RUN` applies shift ticks.

The transitions are:
- `T_READS_DONE` (`ST_FETCH` to `ST_SETTLE`) fires after the read of the last row.
- `T_ARM` (`ST_SETTLE` to `ST_RUN`) is unconditional.
- `T_GLYPH_DONE` (`ST_RUN` to `ST_FETCH`) fires on the sixteenth shift tick and advances the glyph index.
- Reset forces `ST_FETCH`.

The glyph being loaded goes into per-row pending registers. A shift moves pending bits into the displayed rows, and empty positions are refilled with zeros. The same operation therefore brings the glyph in during ticks 1 to 8 and takes it out during ticks 9 to 16. The tick enables come from clock dividers outside this block.

Top module: `glyph_scroller`

## Requirements
- R1: The synchronous active-low reset `rst_n` clears `row_sel` and `col_data` to zero, resets the scan row to 0 and the glyph index to 0, and puts the block in `ST_FETCH`. A fetch of glyph 0 therefore follows release.
- R2: A fetch holds `rom_rd` high for 8 consecutive cycles, with `rom_addr` = glyph*8 + row for rows 0 to 7 in ascending order (glyph index in bits 5:3, row in bits 2:0). ROM data is taken one cycle after its address. Shift ticks are accepted from the second cycle after `rom_rd` falls.
- R3: At shift count zero, which is every state entered after a completed fetch, the display is blank and the whole glyph is pending.
- R4: Left (`dir_sel`=00). Each tick moves every row one place toward bit 7, and the next pending bit (taken from bit 7 downward) enters bit 0. After k ticks (k≤8), row r equals glyph row r shifted right by 8-k. `col_data` bit 7 is the leftmost column.
- R5: Right (`dir_sel`=01). Each tick moves every row one place toward bit 0, and pending bits enter at bit 7 starting from bit 0. After k ticks (k≤8), row r equals glyph row r shifted left by 8-k, truncated to 8 bits.
- R6: Up (`dir_sel`=10, row 0 is the top). Each tick moves rows one place toward row 0, and pending glyph rows enter at row 7 starting with glyph row 0. After k ticks (k≤8), row r equals glyph row r-(8-k), or zero when that index is negative.
- R7: Down (`dir_sel`=11). Each tick moves rows one place toward row 7, and pending glyph rows enter at row 0 starting with glyph row 7. After k ticks (k≤8), row r equals glyph row r+8-k when r<k, and zero otherwise.
- R8: Ticks 9 to 16 continue in the same direction, with zeros filling the positions that are vacated. After tick k, the image equals the full glyph moved k-8 places, with zero fill.
- R9: The sixteenth tick increments the glyph index, wrapping from 7 to 0, and starts a fetch of that glyph.
- R10: Shift ticks that arrive while a fetch or the settle cycle is in progress have no effect. After the fetch the display is blank, and the first tick shows the k=1 image.
- R11: On each `scan_tick`, `row_sel` becomes the one-hot code of the scan row (bit r for row r) and `col_data` becomes that row's displayed pattern. The scan row then advances 0..7 and wraps to 0. Both outputs hold between scan ticks, so a shift becomes visible only at the next scan step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_sel | input | 2 | Scroll direction: 00 left, 01 right, 10 up, 11 down |
| shift_tick | input | 1 | One-cycle enable for one scroll step |
| scan_tick | input | 1 | One-cycle enable for one row-scan step |
| rom_rd | output | 1 | Read strobe to the glyph ROM |
| rom_addr | output | 6 | Glyph ROM address {glyph, row} |
| rom_data | input | 8 | Glyph row, valid the cycle after the read |
| row_sel | output | 8 | One-hot active-high row select |
| col_data | output | 8 | Column pattern of the selected row, bit 7 leftmost |

## Verification
The assertions rely on a few properties of the inputs:
- Reset is held low for at least two cycles, so that `rom_rd` has settled high before checking resumes. Otherwise a read strobe rising out of reset would look like a glyph advance.
- `scan_tick` is a single-cycle enable that follows the clock.
- The ROM returns data exactly one cycle after a strobed address.

The stimulus respects these points:
- It holds reset for four cycles at start-up and two cycles in mid-run.
- It raises and lowers every tick on falling clock edges.
- It serves reads from a bench memory with a one-cycle registered output.
- It changes `dir_sel` only while the shift count is zero.

// File: rtl/scroll_pkg.sv
package scroll_pkg;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2
    } scroll_state_e;

    typedef enum logic [1:0] {
        DIR_LEFT  = 2'b00,
        DIR_RIGHT = 2'b01,
        DIR_UP    = 2'b10,
        DIR_DOWN  = 2'b11
    } scroll_dir_e;

endpackage

// File: rtl/scroll_fsm.sv
module scroll_fsm
    import scroll_pkg::*;
#(
    parameter int DIM    = 8,
    parameter int GLYPHS = 8,
    localparam int RW = $clog2(DIM),
    localparam int GW = $clog2(GLYPHS),
    localparam int AW = GW + RW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_tick,
    output logic          rom_rd,
    output logic [AW-1:0] rom_addr,
    output logic          plane_clear,
    output logic          step_en
);

    localparam int TW = $clog2(2 * DIM);
    localparam logic [RW-1:0] ROW_LAST   = RW'(DIM - 1);
    localparam logic [TW-1:0] TICK_LAST  = TW'(2 * DIM - 1);
    localparam logic [GW-1:0] GLYPH_LAST = GW'(GLYPHS - 1);

    scroll_state_e state_q, state_d;
    logic [RW-1:0] fetch_q;
    logic [TW-1:0] tick_q;
    logic [GW-1:0] glyph_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  if (fetch_q == ROW_LAST) state_d = ST_SETTLE;   // T_READS_DONE
            ST_SETTLE: state_d = ST_RUN;                               // T_ARM
            ST_RUN:    if (shift_tick && tick_q == TICK_LAST)
                           state_d = ST_FETCH;                         // T_GLYPH_DONE
            default:   state_d = ST_FETCH;
        endcase
    end

    // output decode
    always_comb begin
        rom_rd      = 1'b0;
        plane_clear = 1'b0;
        step_en     = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                rom_rd      = 1'b1;
                plane_clear = 1'b1;
            end
            ST_SETTLE: begin
                rom_rd = 1'b0;
            end
            ST_RUN: begin
                step_en = shift_tick;
            end
            default: begin
                rom_rd = 1'b0;
            end
        endcase
    end

    // row, tick and glyph counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q <= '0;
            tick_q  <= '0;
            glyph_q <= '0;
        end else begin
            if (state_q == ST_FETCH) begin
                fetch_q <= (fetch_q == ROW_LAST) ? '0 : fetch_q + 1'b1;
            end
            if (state_q == ST_FETCH) begin
                tick_q <= '0;
            end else if (step_en) begin
                tick_q <= (tick_q == TICK_LAST) ? '0 : tick_q + 1'b1;
            end
            if (step_en && tick_q == TICK_LAST) begin
                glyph_q <= (glyph_q == GLYPH_LAST) ? '0 : glyph_q + 1'b1;
            end
        end
    end

    assign rom_addr = {glyph_q, fetch_q};

endmodule

// File: rtl/glyph_plane.sv
module glyph_plane
    import scroll_pkg::*;
#(
    parameter int DIM = 8,
    localparam int RW = $clog2(DIM)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    rd_i,
    input  logic [RW-1:0]           rd_row_i,
    input  logic [DIM-1:0]          rd_data_i,
    input  logic                    step_i,
    input  scroll_dir_e             dir_i,
    output logic [DIM-1:0][DIM-1:0] rows_o
);

    logic                    cap_vld_q;
    logic [RW-1:0]           cap_row_q;
    logic [DIM-1:0][DIM-1:0] disp_all;
    logic [DIM-1:0][DIM-1:0] pend_all;

    // ROM data returns one cycle after the strobe: remember which row it is
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld_q <= 1'b0;
            cap_row_q <= '0;
        end else begin
            cap_vld_q <= rd_i;
            cap_row_q <= rd_row_i;
        end
    end

    for (genvar r = 0; r < DIM; r++) begin : g_row
        logic [DIM-1:0] disp_q, pend_q, disp_d, pend_d;
        logic [DIM-1:0] below_disp, below_pend, above_disp, above_pend;

        // neighbour feeding this row on an upward move
        if (r == DIM - 1) begin : g_up_edge
            assign below_disp = pend_all[0];
            assign below_pend = '0;
        end else begin : g_up_mid
            assign below_disp = disp_all[r+1];
            assign below_pend = pend_all[r+1];
        end

        // neighbour feeding this row on a downward move
        if (r == 0) begin : g_dn_edge
            assign above_disp = pend_all[DIM-1];
            assign above_pend = '0;
        end else begin : g_dn_mid
            assign above_disp = disp_all[r-1];
            assign above_pend = pend_all[r-1];
        end

        always_comb begin
            disp_d = disp_q;
            pend_d = pend_q;
            unique case (dir_i)
                DIR_LEFT: begin
                    disp_d = {disp_q[DIM-2:0], pend_q[DIM-1]};
                    pend_d = {pend_q[DIM-2:0], 1'b0};
                end
                DIR_RIGHT: begin
                    disp_d = {pend_q[0], disp_q[DIM-1:1]};
                    pend_d = {1'b0, pend_q[DIM-1:1]};
                end
                DIR_UP: begin
                    disp_d = below_disp;
                    pend_d = below_pend;
                end
                DIR_DOWN: begin
                    disp_d = above_disp;
                    pend_d = above_pend;
                end
                default: begin
                    disp_d = disp_q;
                    pend_d = pend_q;
                end
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                disp_q <= '0;
                pend_q <= '0;
            end else begin
                if (clear_i) begin
                    disp_q <= '0;
                end else if (step_i) begin
                    disp_q <= disp_d;
                end
                if (cap_vld_q && cap_row_q == RW'(r)) begin
                    pend_q <= rd_data_i;
                end else if (step_i) begin
                    pend_q <= pend_d;
                end
            end
        end

        assign disp_all[r] = disp_q;
        assign pend_all[r] = pend_q;
    end

    assign rows_o = disp_all;

endmodule

// File: rtl/scan_driver.sv
module scan_driver #(
    parameter int DIM = 8,
    localparam int RW = $clog2(DIM)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scan_tick,
    input  logic [DIM-1:0][DIM-1:0] rows_i,
    output logic [DIM-1:0]          row_sel,
    output logic [DIM-1:0]          col_data
);

    localparam logic [RW-1:0]  SCAN_LAST = RW'(DIM - 1);
    localparam logic [DIM-1:0] SEL_ONE   = DIM'(1);

    logic [RW-1:0] scan_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_q   <= '0;
            row_sel  <= '0;
            col_data <= '0;
        end else if (scan_tick) begin
            row_sel  <= SEL_ONE << scan_q;
            col_data <= rows_i[scan_q];
            scan_q   <= (scan_q == SCAN_LAST) ? '0 : scan_q + 1'b1;
        end
    end

endmodule

// File: rtl/glyph_scroller.sv
module glyph_scroller
    import scroll_pkg::*;
#(
    parameter int DIM    = 8,
    parameter int GLYPHS = 8,
    localparam int RW = $clog2(DIM),
    localparam int GW = $clog2(GLYPHS),
    localparam int AW = GW + RW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     dir_sel,
    input  logic           shift_tick,
    input  logic           scan_tick,
    output logic           rom_rd,
    output logic [AW-1:0]  rom_addr,
    input  logic [DIM-1:0] rom_data,
    output logic [DIM-1:0] row_sel,
    output logic [DIM-1:0] col_data
);

    logic                    plane_clear;
    logic                    step_en;
    logic [DIM-1:0][DIM-1:0] rows;

    scroll_fsm #(.DIM(DIM), .GLYPHS(GLYPHS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_tick (shift_tick),
        .rom_rd     (rom_rd),
        .rom_addr   (rom_addr),
        .plane_clear(plane_clear),
        .step_en    (step_en)
    );

    glyph_plane #(.DIM(DIM)) u_plane (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (plane_clear),
        .rd_i     (rom_rd),
        .rd_row_i (rom_addr[RW-1:0]),
        .rd_data_i(rom_data),
        .step_i   (step_en),
        .dir_i    (scroll_dir_e'(dir_sel)),
        .rows_o   (rows)
    );

    scan_driver #(.DIM(DIM)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_tick(scan_tick),
        .rows_i   (rows),
        .row_sel  (row_sel),
        .col_data (col_data)
    );

endmodule

// File: rtl/glyph_scroller_chk.sv
module glyph_scroller_chk #(
    parameter int DIM    = 8,
    parameter int GLYPHS = 8,
    localparam int RW = $clog2(DIM),
    localparam int GW = $clog2(GLYPHS),
    localparam int AW = GW + RW
) (
    input logic           clk,
    input logic           rst_n,
    input logic           scan_tick,
    input logic           rom_rd,
    input logic [AW-1:0]  rom_addr,
    input logic [DIM-1:0] row_sel,
    input logic [DIM-1:0] col_data
);

    localparam logic [RW-1:0] ROW_LAST = RW'(DIM - 1);
    localparam logic [GW-1:0] G_ONE    = GW'(1);
    localparam logic [AW-1:0] A_ONE    = AW'(1);

    p_onehot_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel));

    p_hold_scan_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(row_sel) && $stable(col_data));

    p_row_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && row_sel != '0) |=>
            row_sel == {$past(row_sel[DIM-2:0]), $past(row_sel[DIM-1])});

    p_first_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_rd) |-> rom_addr[RW-1:0] == '0);

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && rom_addr[RW-1:0] != ROW_LAST) |=>
            rom_rd && rom_addr == $past(rom_addr) + A_ONE);

    p_glyph_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_rd) |-> rom_addr[AW-1:RW] == $past(rom_addr[AW-1:RW]) + G_ONE);

endmodule

bind glyph_scroller glyph_scroller_chk #(.DIM(DIM), .GLYPHS(GLYPHS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_tick(scan_tick),
    .rom_rd   (rom_rd),
    .rom_addr (rom_addr),
    .row_sel  (row_sel),
    .col_data (col_data)
);

// File: tb/tb_glyph_scroller.sv
`timescale 1ns/1ps
module tb_glyph_scroller;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] dir_sel = 2'b00;
    logic       shift_tick = 1'b0;
    logic       scan_tick = 1'b0;
    logic       rom_rd;
    logic [5:0] rom_addr;
    logic [7:0] rom_data = 8'h00;
    logic [7:0] row_sel;
    logic [7:0] col_data;

    int   checks = 0;
    int   errors = 0;
    int   srow = 0;
    bit   done = 1'b0;
    logic [7:0] last_sel = 8'h00;
    logic [7:0] last_col = 8'h00;
    logic [7:0] mem [64];

    always #2 clk = ~clk;

    glyph_scroller dut (
        .clk(clk), .rst_n(rst_n), .dir_sel(dir_sel), .shift_tick(shift_tick),
        .scan_tick(scan_tick), .rom_rd(rom_rd), .rom_addr(rom_addr),
        .rom_data(rom_data), .row_sel(row_sel), .col_data(col_data)
    );

    function automatic logic [7:0] gly(input int g, input int r);
        return 8'((g * 53 + r * 29 + 60) ^ (129 >> (r % 4)));
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = gly(i / 8, i % 8);
    end

    always @(posedge clk) begin
        if (rom_rd) rom_data <= mem[rom_addr];
    end

    // expected displayed row r of glyph g after k shift ticks in direction d
    function automatic logic [7:0] exp_row(input logic [1:0] d, input int k,
                                           input int g, input int r);
        if (k == 0) return 8'h00;
        case (d)
            2'b00: return (k <= 8) ? 8'(gly(g, r) >> (8 - k)) : 8'(gly(g, r) << (k - 8));
            2'b01: return (k <= 8) ? 8'(gly(g, r) << (8 - k)) : 8'(gly(g, r) >> (k - 8));
            2'b10: begin
                if (k <= 8) return (r >= 8 - k) ? gly(g, r - (8 - k)) : 8'h00;
                return (r + k - 8 <= 7) ? gly(g, r + k - 8) : 8'h00;
            end
            default: begin
                if (k <= 8) return (r < k) ? gly(g, r + 8 - k) : 8'h00;
                return (r >= k - 8) ? gly(g, r - (k - 8)) : 8'h00;
            end
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic tick_shift();
        shift_tick = 1'b1;
        @(negedge clk);
        shift_tick = 1'b0;
    endtask

    // full scan of the 8 rows, comparing against the expected image
    task automatic scan_frame(input string tag, input logic [1:0] d, input int k, input int g);
        for (int i = 0; i < 8; i++) begin
            scan_tick = 1'b1;
            @(negedge clk);
            scan_tick = 1'b0;
            chk({tag, " R11 row_sel"}, {24'h0, row_sel}, 32'(8'h01 << srow));
            chk({tag, " col_data"}, {24'h0, col_data}, {24'h0, exp_row(d, k, g, srow)});
            last_sel = row_sel;
            last_col = col_data;
            srow = (srow + 1) % 8;
        end
    endtask

    // called at the falling edge of the first fetch cycle
    task automatic check_fetch(input string tag, input int g, input bit noisy);
        for (int r = 0; r < 8; r++) begin
            chk({tag, " rom_rd"}, {31'h0, rom_rd}, 32'd1);
            chk({tag, " rom_addr"}, {26'h0, rom_addr}, 32'(g * 8 + r));
            shift_tick = noisy;
            @(negedge clk);
        end
        chk({tag, " rom_rd low in settle"}, {31'h0, rom_rd}, 32'd0);
        shift_tick = noisy;
        @(negedge clk);
        shift_tick = 1'b0;
    endtask

    function automatic string dir_tag(input logic [1:0] d);
        case (d)
            2'b00:   return "R4";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run_cycle(input logic [1:0] d, input int g, input int nextg, input bit noisy);
        dir_sel = d;
        for (int k = 1; k <= 15; k++) begin
            tick_shift();
            if (k == 4) begin
                chk("R11 row_sel held across shift", {24'h0, row_sel}, {24'h0, last_sel});
                chk("R11 col_data held across shift", {24'h0, col_data}, {24'h0, last_col});
            end
            scan_frame((k <= 8) ? dir_tag(d) : "R8", d, k, g);
        end
        tick_shift();
        check_fetch(noisy ? "R10 R9 fetch" : "R9 fetch", nextg, noisy);
        scan_frame(noisy ? "R10 R3 blank" : "R3 blank", d, 0, nextg);
    endtask

    task automatic skip_cycle(input string tag, input int nextg);
        repeat (16) tick_shift();
        check_fetch(tag, nextg, 1'b0);
    endtask

    task automatic test_reset();
        repeat (4) @(negedge clk);
        chk("R1 row_sel in reset", {24'h0, row_sel}, 32'h0);
        chk("R1 col_data in reset", {24'h0, col_data}, 32'h0);
        rst_n = 1'b1;
        srow = 0;
        check_fetch("R1 R2 first fetch", 0, 1'b0);
        scan_frame("R3 blank after fetch", 2'b00, 0, 0);
    endtask

    task automatic test_mid_reset();
        dir_sel = 2'b00;
        repeat (5) tick_shift();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 row_sel after mid reset", {24'h0, row_sel}, 32'h0);
        chk("R1 col_data after mid reset", {24'h0, col_data}, 32'h0);
        rst_n = 1'b1;
        srow = 0;
        check_fetch("R1 fetch after mid reset", 0, 1'b0);
        tick_shift();
        scan_frame("R1 R4 first tick after reset", 2'b00, 1, 0);
    endtask

    initial begin
        test_reset();
        run_cycle(2'b00, 0, 1, 1'b0);   // left
        run_cycle(2'b01, 1, 2, 1'b1);   // right, ticks during the next fetch
        run_cycle(2'b10, 2, 3, 1'b0);   // up
        run_cycle(2'b11, 3, 4, 1'b0);   // down
        skip_cycle("R9 fetch 5", 5);
        skip_cycle("R9 fetch 6", 6);
        skip_cycle("R9 fetch 7", 7);
        skip_cycle("R9 wrap to 0", 0);
        test_mid_reset();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule